// File: doc/BRIEF.md
# Configurable PAL Output Macrocell

This block is one output cell of a small programmable sum-of-products device. It receives the product terms that belong to it, plus a shared clock and a shared active-low enable pin. Three bits pick its configuration: a device-wide "no registers" bit, a device-wide "complex mode" bit and a per-cell "pin is I/O" bit. A fourth per-cell bit picks the output polarity. From these it produces the value driven toward the pin, the tristate enable for the pad, and the signal returned to the AND array.

Five configurations are decoded. In registered output, the cell captures the OR of all its terms on the rising clock edge and drives the pin when the shared enable pin is low. There are two combinational I/O variants. In both, the last term becomes the pad enable and the pin itself is read back. In dedicated combinational output, the pin is always driven. In dedicated input, the pad is off and the cell passes the neighbouring pin to the array. The two end cells of a device read the OE pin or the clock pin as their neighbour. In those two cells the feedback mux is steered by the "no registers" bit and not by the "complex mode" bit. The two middle cells have no feedback at all in dedicated output mode. A test preload and a power-up reset act on the flip-flop.

Top module: `pal_macrocell`

## Requirements
- R1: With code (sg0,sg1,sl0)=(0,1,0) (registered), pin_out equals the flip-flop state, pin_oe equals the inverse of oe_n, and fb equals the inverse of the flip-flop state.
- R2: In registered code, with rst and preload_en low, a rising clk loads the flip-flop with the polarity-adjusted OR of all TERMS terms. In every other code the flip-flop keeps its value.
- R3: The polarity-adjusted sum equals the OR when sl1=1 and its inverse when sl1=0.
- R4: With code (0,1,1) or (1,1,1), pin_out is the polarity-adjusted OR of terms[TERMS-2:0] and pin_oe equals terms[TERMS-1]. For a middle cell, and for an end cell with code (0,1,1), fb equals pin_in.
- R5: With code (1,0,0), pin_out is the polarity-adjusted OR of all terms and pin_oe is 1. For an ordinary cell, fb equals the neighbour input adj_in.
- R6: With code (1,0,1), pin_oe is 0 and fb equals the neighbour input.
- R7: The neighbour input is oe_n for CELL_KIND=1 and the clk pin level for CELL_KIND=2. In these end cells, codes (1,1,1) and (1,0,0) also return the neighbour input on fb.
- R8: A cell built with NO_FB=1 drives fb to 0 in code (1,0,0).
- R9: rst high at a rising clk clears the flip-flop to 0. Otherwise preload_en high loads preload_val, and this takes priority over normal capture.
- R10: Codes (0,0,0), (0,0,1) and (1,1,0) force pin_oe=0 and fb=0 and raise cfg_err. Every listed code keeps cfg_err at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock pin; also the neighbour level for the high end cell |
| rst | input | 1 | Synchronous power-up reset of the flip-flop |
| terms | input | TERMS | Product terms of this cell; the top one doubles as the I/O enable term |
| sg0 | input | 1 | Global bit: device has no registers |
| sg1 | input | 1 | Global bit: complex-mode device |
| sl0 | input | 1 | Local bit: pin used as I/O or input |
| sl1 | input | 1 | Local polarity bit, 1 = active high |
| oe_n | input | 1 | Shared active-low output enable pin |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 1 | Value written by the preload |
| pin_in | input | 1 | Level seen on this cell's own pin |
| adj_in | input | 1 | Level of the neighbouring pin (ordinary cells) |
| pin_out | output | 1 | Value toward the pad |
| pin_oe | output | 1 | Pad tristate enable |
| fb | output | 1 | Feedback to the AND array |
| cfg_err | output | 1 | Unlisted configuration code |

## Verification
The bench runs four copies side by side: an ordinary cell, both end cells and a middle cell with no feedback. All four see every configuration code with varied terms, pins and polarity. A feedback mux steered by the wrong global bit in an end cell would return pin_in where the OE or clock level belongs. The high end cell is therefore also sampled while the clock is high, to tell a real clock read from a constant. Random preloads and mode changes after a capture expose a flip-flop that keeps loading outside registered mode, or one that lets capture win over a preload. The seven-term OR is tested with only the top term set, so a design that sums all eight terms in I/O mode shows the wrong pin_out.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;

    typedef enum logic [2:0] {
        MD_REG,
        MD_CIO_REG,
        MD_COUT,
        MD_DIN,
        MD_CIO_NREG,
        MD_BAD
    } mode_e;

    typedef enum logic [1:0] {
        FB_REG,
        FB_PIN,
        FB_ADJ,
        FB_ZERO
    } fb_sel_e;

    typedef enum logic [1:0] {
        OE_PIN,
        OE_TERM,
        OE_ON,
        OE_OFF
    } oe_sel_e;

    typedef struct packed {
        mode_e   mode;
        fb_sel_e fb;
        oe_sel_e oe;
        logic    narrow;
        logic    err;
    } cfg_t;

    localparam int KIND_MID    = 0;
    localparam int KIND_END_OE = 1;
    localparam int KIND_END_CK = 2;

    function automatic mode_e decode_mode(input logic g0, input logic g1, input logic l0);
        case ({g0, g1, l0})
            3'b010:  return MD_REG;
            3'b011:  return MD_CIO_REG;
            3'b100:  return MD_COUT;
            3'b101:  return MD_DIN;
            3'b111:  return MD_CIO_NREG;
            default: return MD_BAD;
        endcase
    endfunction

endpackage

// File: rtl/pal_mc_decode.sv
module pal_mc_decode
    import pal_mc_pkg::*;
#(
    parameter bit END_CELL = 1'b0,
    parameter bit NO_FB    = 1'b0
) (
    input  logic sg0,
    input  logic sg1,
    input  logic sl0,
    output cfg_t cfg
);
    logic  fb_ctl;
    mode_e mode;

    // End cells steer the feedback mux from the "no registers" bit.
    assign fb_ctl = END_CELL ? ~sg0 : sg1;
    assign mode   = decode_mode(sg0, sg1, sl0);

    always_comb begin
        cfg.mode   = mode;
        cfg.err    = (mode == MD_BAD);
        cfg.narrow = (mode == MD_CIO_REG) || (mode == MD_CIO_NREG);

        case (mode)
            MD_REG:                  cfg.oe = OE_PIN;
            MD_CIO_REG, MD_CIO_NREG: cfg.oe = OE_TERM;
            MD_COUT:                 cfg.oe = OE_ON;
            default:                 cfg.oe = OE_OFF;
        endcase

        if (mode == MD_BAD) begin
            cfg.fb = FB_ZERO;
        end else if (fb_ctl) begin
            cfg.fb = sl0 ? FB_PIN : FB_REG;
        end else if (!END_CELL && NO_FB && mode == MD_COUT) begin
            cfg.fb = FB_ZERO;
        end else begin
            cfg.fb = FB_ADJ;
        end
    end
endmodule

// File: rtl/pal_mc_sum.sv
module pal_mc_sum #(
    parameter int TERMS = 8
) (
    input  logic [TERMS-1:0] terms,
    output logic             sum_all,
    output logic             sum_narrow
);
    logic [TERMS-1:0] acc;

    assign acc[0] = terms[0];
    for (genvar g = 1; g < TERMS; g++) begin : g_or
        assign acc[g] = acc[g-1] | terms[g];
    end

    assign sum_all    = acc[TERMS-1];
    assign sum_narrow = acc[TERMS-2];
endmodule

// File: rtl/pal_mc_flop.sv
module pal_mc_flop (
    input  logic clk,
    input  logic rst,
    input  logic preload_en,
    input  logic preload_val,
    input  logic capture,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (preload_en) begin
            q <= preload_val;
        end else if (capture) begin
            q <= d;
        end
    end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import pal_mc_pkg::*;
#(
    parameter int TERMS     = 8,
    parameter int CELL_KIND = KIND_MID,
    parameter bit NO_FB     = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TERMS-1:0] terms,
    input  logic             sg0,
    input  logic             sg1,
    input  logic             sl0,
    input  logic             sl1,
    input  logic             oe_n,
    input  logic             preload_en,
    input  logic             preload_val,
    input  logic             pin_in,
    input  logic             adj_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             fb,
    output logic             cfg_err
);
    localparam bit END_CELL = (CELL_KIND != KIND_MID);

    cfg_t cfg;
    logic sum_all, sum_narrow, sum_sel, pol, q, adj;

    pal_mc_decode #(.END_CELL(END_CELL), .NO_FB(NO_FB)) u_dec (
        .sg0 (sg0),
        .sg1 (sg1),
        .sl0 (sl0),
        .cfg (cfg)
    );

    pal_mc_sum #(.TERMS(TERMS)) u_sum (
        .terms      (terms),
        .sum_all    (sum_all),
        .sum_narrow (sum_narrow)
    );

    assign sum_sel = cfg.narrow ? sum_narrow : sum_all;
    assign pol     = sum_sel ^ ~sl1;

    pal_mc_flop u_flop (
        .clk         (clk),
        .rst         (rst),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .capture     (cfg.mode == MD_REG),
        .d           (pol),
        .q           (q)
    );

    if (CELL_KIND == KIND_END_OE) begin : g_adj_oe
        assign adj = oe_n;
    end else if (CELL_KIND == KIND_END_CK) begin : g_adj_ck
        assign adj = clk;
    end else begin : g_adj_pin
        assign adj = adj_in;
    end

    assign pin_out = (cfg.mode == MD_REG) ? q : pol;
    assign cfg_err = cfg.err;

    always_comb begin
        case (cfg.oe)
            OE_PIN:  pin_oe = ~oe_n;
            OE_TERM: pin_oe = terms[TERMS-1];
            OE_ON:   pin_oe = 1'b1;
            default: pin_oe = 1'b0;
        endcase
        case (cfg.fb)
            FB_REG:  fb = ~q;
            FB_PIN:  fb = pin_in;
            FB_ADJ:  fb = adj;
            default: fb = 1'b0;
        endcase
    end
endmodule

// File: rtl/pal_macrocell_chk.sv
module pal_macrocell_chk #(
    parameter int TERMS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [TERMS-1:0] terms,
    input logic             sg0,
    input logic             sg1,
    input logic             sl0,
    input logic             sl1,
    input logic             oe_n,
    input logic             preload_en,
    input logic             preload_val,
    input logic             pin_in,
    input logic             pin_out,
    input logic             pin_oe,
    input logic             fb,
    input logic             cfg_err
);
    logic is_reg, is_cio_reg, is_cio, is_din, is_bad;
    assign is_reg     = !sg0 && sg1 && !sl0;
    assign is_cio_reg = !sg0 && sg1 && sl0;
    assign is_cio     = sg1 && sl0;
    assign is_din     = sg0 && !sg1 && sl0;
    assign is_bad     = (!sg0 && !sg1) || (sg0 && sg1 && !sl0);

    a_r1_reg_enable: assert property (@(posedge clk) disable iff (rst)
        is_reg |-> pin_oe == !oe_n);

    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        (is_reg && !preload_en) |=>
        (!is_reg || pin_out == $past(sl1 ? (|terms) : !(|terms))));

    a_r4_io_enable: assert property (@(posedge clk) disable iff (rst)
        is_cio |-> pin_oe == terms[TERMS-1]);

    a_r4_io_feedback: assert property (@(posedge clk) disable iff (rst)
        is_cio_reg |-> fb == pin_in);

    a_r6_input_off: assert property (@(posedge clk) disable iff (rst)
        is_din |-> !pin_oe);

    a_r9_preload: assert property (@(posedge clk) disable iff (rst)
        preload_en |=> (!is_reg || pin_out == $past(preload_val)));

    a_r10_bad_code: assert property (@(posedge clk) disable iff (rst)
        is_bad |-> (cfg_err && !pin_oe && !fb));

    a_r10_good_code: assert property (@(posedge clk) disable iff (rst)
        !is_bad |-> !cfg_err);
endmodule

bind pal_macrocell pal_macrocell_chk #(.TERMS(TERMS)) u_chk (.*);

// File: tb/pal_macrocell_tb.sv
module pal_macrocell_tb;
    localparam int TERMS = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [TERMS-1:0] terms = '0;
    logic sg0 = 1'b0, sg1 = 1'b1, sl0 = 1'b0, sl1 = 1'b1;
    logic oe_n = 1'b0, preload_en = 1'b0, preload_val = 1'b0;
    logic pin_in = 1'b0, adj_in = 1'b0;

    logic [3:0] o_out, o_oe, o_fb, o_err;

    int total = 0;
    int bad = 0;
    bit run_chk = 1'b0;
    logic m_q = 1'b0;
    string m_qtag = "R9";
    int seed = 12345;

    always #10 clk = ~clk;

    pal_macrocell #(.TERMS(TERMS), .CELL_KIND(0), .NO_FB(1'b0)) u_dut (
        .clk(clk), .rst(rst), .terms(terms), .sg0(sg0), .sg1(sg1), .sl0(sl0), .sl1(sl1),
        .oe_n(oe_n), .preload_en(preload_en), .preload_val(preload_val),
        .pin_in(pin_in), .adj_in(adj_in),
        .pin_out(o_out[0]), .pin_oe(o_oe[0]), .fb(o_fb[0]), .cfg_err(o_err[0]));

    pal_macrocell #(.TERMS(TERMS), .CELL_KIND(1), .NO_FB(1'b0)) u_lo (
        .clk(clk), .rst(rst), .terms(terms), .sg0(sg0), .sg1(sg1), .sl0(sl0), .sl1(sl1),
        .oe_n(oe_n), .preload_en(preload_en), .preload_val(preload_val),
        .pin_in(pin_in), .adj_in(adj_in),
        .pin_out(o_out[1]), .pin_oe(o_oe[1]), .fb(o_fb[1]), .cfg_err(o_err[1]));

    pal_macrocell #(.TERMS(TERMS), .CELL_KIND(2), .NO_FB(1'b0)) u_hi (
        .clk(clk), .rst(rst), .terms(terms), .sg0(sg0), .sg1(sg1), .sl0(sl0), .sl1(sl1),
        .oe_n(oe_n), .preload_en(preload_en), .preload_val(preload_val),
        .pin_in(pin_in), .adj_in(adj_in),
        .pin_out(o_out[2]), .pin_oe(o_oe[2]), .fb(o_fb[2]), .cfg_err(o_err[2]));

    pal_macrocell #(.TERMS(TERMS), .CELL_KIND(0), .NO_FB(1'b1)) u_mid (
        .clk(clk), .rst(rst), .terms(terms), .sg0(sg0), .sg1(sg1), .sl0(sl0), .sl1(sl1),
        .oe_n(oe_n), .preload_en(preload_en), .preload_val(preload_val),
        .pin_in(pin_in), .adj_in(adj_in),
        .pin_out(o_out[3]), .pin_oe(o_oe[3]), .fb(o_fb[3]), .cfg_err(o_err[3]));

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Behavioural flip-flop model (R2, R9).
    always @(posedge clk) begin
        if (rst) begin
            m_q = 1'b0;
            m_qtag = "R9";
        end else if (preload_en) begin
            m_q = preload_val;
            m_qtag = "R9";
        end else if ({sg0, sg1, sl0} == 3'b010) begin
            m_q = (|terms) ^ ~sl1;
            m_qtag = "R2";
        end
    end

    task automatic check_cell(input int idx, input int kind, input bit nofb, input logic clkv);
        logic [2:0] code;
        logic adj, p_all, p_nar;
        logic eo, eoe, efb, eerr;
        string tag;
        string nm;
        code  = {sg0, sg1, sl0};
        adj   = (kind == 1) ? oe_n : (kind == 2) ? clkv : adj_in;
        p_all = (|terms) ^ ~sl1;
        p_nar = (|terms[TERMS-2:0]) ^ ~sl1;
        eerr  = 1'b0;
        case (code)
            3'b010: begin
                eo = m_q; eoe = ~oe_n; efb = ~m_q; tag = {"R1 ", m_qtag};
            end
            3'b011, 3'b111: begin
                eo = p_nar; eoe = terms[TERMS-1];
                if (code == 3'b111 && kind != 0) begin
                    efb = adj; tag = "R7 R3";
                end else begin
                    efb = pin_in; tag = "R4 R3";
                end
            end
            3'b100: begin
                eo = p_all; eoe = 1'b1;
                if (nofb) begin
                    efb = 1'b0; tag = "R8 R3";
                end else begin
                    efb = adj; tag = (kind != 0) ? "R7 R3" : "R5 R3";
                end
            end
            3'b101: begin
                eo = p_all; eoe = 1'b0; efb = adj;
                tag = (kind != 0) ? "R7 R3" : "R6 R3";
            end
            default: begin
                eo = p_all; eoe = 1'b0; efb = 1'b0; eerr = 1'b1; tag = "R10";
            end
        endcase
        nm = $sformatf("cell%0d code=%b", idx, code);
        chk(o_out[idx], eo, tag, {nm, " pin_out"});
        chk(o_oe[idx], eoe, tag, {nm, " pin_oe"});
        chk(o_fb[idx], efb, tag, {nm, " fb"});
        chk(o_err[idx], eerr, "R10", {nm, " cfg_err"});
    endtask

    always @(negedge clk) begin
        if (run_chk) begin
            check_cell(0, 0, 1'b0, 1'b0);
            check_cell(1, 1, 1'b0, 1'b0);
            check_cell(2, 2, 1'b0, 1'b0);
            check_cell(3, 0, 1'b1, 1'b0);
        end
    end

    // High end cell sampled while clk is high: the neighbour is the clock pin (R7).
    always @(posedge clk) begin
        #5;
        if (run_chk && sg0 && !(sg1 && !sl0)) begin
            check_cell(2, 2, 1'b0, 1'b1);
        end
    end

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fff;
    endfunction

    task automatic drive(input logic [2:0] code, input logic [TERMS-1:0] t, input logic pol);
        {sg0, sg1, sl0} = code;
        terms = t;
        sl1 = pol;
    endtask

    initial begin
        // Reset held in registered mode, then checked: R9 power-up clear.
        drive(3'b010, 8'hFF, 1'b1);
        preload_en = 1'b1;
        preload_val = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        run_chk = 1'b1;
        #1;
        rst = 1'b0;
        // R9: preload wins over capture of a zero sum.
        terms = 8'h00;
        sl1 = 1'b1;
        preload_val = 1'b1;
        @(negedge clk); #1;
        preload_en = 1'b0;
        // R2: normal capture, both polarities.
        @(negedge clk); #1;
        terms = 8'h10; sl1 = 1'b0;
        @(negedge clk); #1;
        // R4: only the top term set, seven-term OR must stay low.
        drive(3'b011, 8'h80, 1'b1); pin_in = 1'b1;
        @(negedge clk); #1;
        drive(3'b111, 8'h80, 1'b1); oe_n = 1'b1; pin_in = 1'b0;
        @(negedge clk); #1;
        // R2: register holds outside registered mode.
        drive(3'b100, 8'h00, 1'b1); adj_in = 1'b1;
        @(negedge clk); #1;
        drive(3'b010, 8'h00, 1'b1);
        @(negedge clk); #1;
        for (int i = 0; i < 600; i++) begin
            int r;
            r = rnd();
            drive(r[2:0], ((r & 32'h8) != 0) ? 8'(rnd()) : 8'((rnd() & 1) << 7), r[4]);
            oe_n        = r[5];
            pin_in      = r[6];
            adj_in      = r[7];
            preload_en  = (r[11:9] == 3'b000);
            preload_val = r[12];
            rst         = (r[14:10] == 5'b11111);
            @(negedge clk); #1;
        end
        rst = 1'b0;
        preload_en = 1'b0;
        @(negedge clk); #1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule